// File: doc/BRIEF.md
# Single-Precision Compare and Min/Max Unit

This block evaluates one single-precision IEEE-754 relation or selection per accepted request. A one-bit function select chooses between the compare group and the min/max group, and a three-bit sub-operation code picks the exact operation within that group. A compare returns a truth value in bit 0 of the result word. A min/max returns one of the two operands, or the canonical quiet NaN. Each request also reports an invalid-operation flag.

The rules for NaN inputs differ between the operations. The ordered relations (less-than, less-or-equal) treat any NaN as invalid. Equality raises the flag only for a signaling NaN. Min/max drops a signaling-NaN operand in favour of the other operand, and it tests the second operand first. A single quiet NaN is skipped silently. The unit has a valid-in/valid-out handshake with a single registered stage. The result stays in the output register until the next accepted request.

Top module: `fpcmp_unit`

## Requirements
- R1: While reset is high, and in the first cycle after it, out_valid, out_result and out_flags are all zero.
- R2: A request taken with in_valid high shows its result with out_valid high in the next cycle. In a cycle with in_valid low, out_valid is low, and out_result and out_flags keep their last values whatever the other inputs do.
- R3: With in_func = 0 (compare), in_sub 0 is less-or-equal, 1 is less-than and 2 is equal. The answer is in out_result bit 0 and bits 31:1 are zero. Ordering is numeric, and -0 equals +0.
- R4: Less-than and less-or-equal return 0 and set out_flags bit 4 (invalid) when either operand is any NaN. out_flags bits 3:0 are always zero.
- R5: Equal returns 0 when either operand is a NaN and sets the invalid flag only when an operand is a signaling NaN. A NaN has exponent bits 30:23 all ones and a nonzero mantissa (bits 22:0). It is signaling when bit 22 is clear and quiet when bit 22 is set.
- R6: With in_func = 1 (min/max), in_sub 0 is minimum and 1 is maximum. The chosen operand is returned bit-exact, and -0 is ordered below +0.
- R7: For min/max, if in_b is a signaling NaN, the result is in_a unchanged and the invalid flag is set.
- R8: For min/max, if in_b is not a signaling NaN but in_a is, the result is in_b and the invalid flag is set.
- R9: For min/max without a signaling NaN, a single quiet-NaN operand is ignored and the other operand is returned with no flag. Two quiet NaNs give 0x7FC00000 with no flag.
- R10: Unused sub-operation codes (3 to 7 for compare, 2 to 7 for min/max) give a result of 0 and no flag, whatever the operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_func | input | 1 | 0 = compare group, 1 = min/max group |
| in_sub | input | 3 | Sub-operation code within the group |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Second operand |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_result | output | 32 | Compare bit in bit 0, or selected value |
| out_flags | output | 5 | Exception flags; bit 4 is invalid |

## Verification
The bench targets signed zeros. A unit that compared raw bits would call -0 and +0 unequal, and a min/max that used numeric equality would return +0 for the minimum. It pairs quiet NaNs against signaling NaNs under each operation. A design that flagged equality on quiet NaNs, or that let the ordered relations pass quiet NaNs without a flag, would show the wrong flag bit. Min/max cases with a signaling NaN in both slots, or a signaling NaN next to a quiet NaN, expose a wrong check order, because such a design returns the other operand. The bench also covers undefined codes, which would otherwise leak a result. It holds the inputs idle between requests, which catches an output register that reloads without a strobe.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;

    localparam int EXP_W        = 8;
    localparam int MAN_W        = 23;
    localparam int FP_W         = 1 + EXP_W + MAN_W;
    localparam int MAG_W        = FP_W - 1;
    localparam int SUB_W        = 3;
    localparam int FLAG_W       = 5;
    localparam int FLAG_INVALID = 4;

    // Quiet NaN with positive sign and only the quiet bit set in the mantissa
    localparam logic [FP_W-1:0] CANON_NAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

    typedef enum logic [2:0] {
        OP_LE   = 3'd0,
        OP_LT   = 3'd1,
        OP_EQ   = 3'd2,
        OP_MIN  = 3'd3,
        OP_MAX  = 3'd4,
        OP_NONE = 3'd5
    } op_e;

    typedef struct packed {
        logic             sign;
        logic             zero;
        logic             nan;
        logic             snan;
        logic [MAG_W-1:0] mag;
    } fp_class_t;

    // Map the group select and the sub-operation code onto one internal operation
    function automatic op_e decode_op(input logic func, input logic [SUB_W-1:0] sub);
        op_e op;
        op = OP_NONE;
        if (!func) begin
            case (sub)
                3'd0:    op = OP_LE;
                3'd1:    op = OP_LT;
                3'd2:    op = OP_EQ;
                default: op = OP_NONE;
            endcase
        end else begin
            case (sub)
                3'd0:    op = OP_MIN;
                3'd1:    op = OP_MAX;
                default: op = OP_NONE;
            endcase
        end
        return op;
    endfunction

endpackage

// File: rtl/fpcmp_classify.sv
module fpcmp_classify
    import fpcmp_pkg::*;
(
    input  logic [FP_W-1:0] op,
    output fp_class_t       cls
);
    logic [EXP_W-1:0] exp_f;
    logic [MAN_W-1:0] man_f;
    logic             exp_max;

    assign exp_f   = op[FP_W-2 -: EXP_W];
    assign man_f   = op[MAN_W-1:0];
    assign exp_max = &exp_f;

    always_comb begin
        cls.sign = op[FP_W-1];
        cls.mag  = op[MAG_W-1:0];
        cls.zero = (op[MAG_W-1:0] == '0);
        cls.nan  = exp_max && (man_f != '0);
        cls.snan = exp_max && (man_f != '0) && !man_f[MAN_W-1];
    end
endmodule

// File: rtl/fpcmp_compare.sv
module fpcmp_compare
    import fpcmp_pkg::*;
(
    input  fp_class_t a,
    input  fp_class_t b,
    input  op_e       op,
    output logic      hit,
    output logic      invalid
);
    logic any_nan, any_snan, both_zero;
    logic num_lt, num_eq;

    assign any_nan   = a.nan  | b.nan;
    assign any_snan  = a.snan | b.snan;
    assign both_zero = a.zero & b.zero;

    // Numeric ordering on sign-magnitude values; signed zeros are one value
    always_comb begin
        if (both_zero)
            num_lt = 1'b0;
        else if (a.sign != b.sign)
            num_lt = a.sign;
        else if (!a.sign)
            num_lt = (a.mag < b.mag);
        else
            num_lt = (b.mag < a.mag);
        num_eq = both_zero || ((a.sign == b.sign) && (a.mag == b.mag));
    end

    always_comb begin
        hit     = 1'b0;
        invalid = 1'b0;
        case (op)
            OP_LE: begin
                hit     = !any_nan && (num_lt || num_eq);
                invalid = any_nan;
            end
            OP_LT: begin
                hit     = !any_nan && num_lt;
                invalid = any_nan;
            end
            OP_EQ: begin
                hit     = !any_nan && num_eq;
                invalid = any_snan;
            end
            default: begin
                hit     = 1'b0;
                invalid = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/fpcmp_select.sv
module fpcmp_select
    import fpcmp_pkg::*;
(
    input  logic [FP_W-1:0] a_val,
    input  logic [FP_W-1:0] b_val,
    input  logic            a_nan,
    input  logic            a_snan,
    input  logic            b_nan,
    input  logic            b_snan,
    input  op_e             op,
    output logic [FP_W-1:0] value,
    output logic            invalid
);
    logic             a_sign, b_sign;
    logic [MAG_W-1:0] a_mag, b_mag;
    logic             a_below;

    assign a_sign = a_val[FP_W-1];
    assign b_sign = b_val[FP_W-1];
    assign a_mag  = a_val[MAG_W-1:0];
    assign b_mag  = b_val[MAG_W-1:0];

    // Total order: negative zero sits below positive zero
    always_comb begin
        if (a_sign != b_sign)
            a_below = a_sign;
        else if (!a_sign)
            a_below = (a_mag < b_mag);
        else
            a_below = (b_mag < a_mag);
    end

    always_comb begin
        value   = '0;
        invalid = 1'b0;
        if (op == OP_MIN || op == OP_MAX) begin
            if (b_snan) begin
                value   = a_val;
                invalid = 1'b1;
            end else if (a_snan) begin
                value   = b_val;
                invalid = 1'b1;
            end else if (a_nan && b_nan) begin
                value = CANON_NAN;
            end else if (a_nan) begin
                value = b_val;
            end else if (b_nan) begin
                value = a_val;
            end else if (op == OP_MIN) begin
                value = a_below ? a_val : b_val;
            end else begin
                value = a_below ? b_val : a_val;
            end
        end
    end
endmodule

// File: rtl/fpcmp_unit.sv
module fpcmp_unit
    import fpcmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_func,
    input  logic [SUB_W-1:0]  in_sub,
    input  logic [FP_W-1:0]   in_a,
    input  logic [FP_W-1:0]   in_b,
    output logic              out_valid,
    output logic [FP_W-1:0]   out_result,
    output logic [FLAG_W-1:0] out_flags
);
    localparam int N_OPS = 2;

    logic [FP_W-1:0] ops [N_OPS];
    fp_class_t       cls [N_OPS];
    op_e             op;

    assign ops[0] = in_a;
    assign ops[1] = in_b;
    assign op     = decode_op(in_func, in_sub);

    for (genvar k = 0; k < N_OPS; k++) begin : g_cls
        fpcmp_classify u_cls (
            .op  (ops[k]),
            .cls (cls[k])
        );
    end

    logic            cmp_hit, cmp_inv;
    logic [FP_W-1:0] sel_val;
    logic            sel_inv;

    fpcmp_compare u_cmp (
        .a       (cls[0]),
        .b       (cls[1]),
        .op      (op),
        .hit     (cmp_hit),
        .invalid (cmp_inv)
    );

    fpcmp_select u_sel (
        .a_val   (in_a),
        .b_val   (in_b),
        .a_nan   (cls[0].nan),
        .a_snan  (cls[0].snan),
        .b_nan   (cls[1].nan),
        .b_snan  (cls[1].snan),
        .op      (op),
        .value   (sel_val),
        .invalid (sel_inv)
    );

    logic [FP_W-1:0]   nxt_result;
    logic [FLAG_W-1:0] nxt_flags;

    always_comb begin
        nxt_flags = '0;
        if (!in_func) begin
            nxt_result               = {{(FP_W-1){1'b0}}, cmp_hit};
            nxt_flags[FLAG_INVALID]  = cmp_inv;
        end else begin
            nxt_result               = sel_val;
            nxt_flags[FLAG_INVALID]  = sel_inv;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_result <= '0;
            out_flags  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_result <= nxt_result;
                out_flags  <= nxt_flags;
            end
        end
    end

    // R2: one registered stage between request and result
    p_latency_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> out_valid == $past(in_valid));

    // R2: no strobe, no change
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(in_valid)) |-> ($stable(out_result) && $stable(out_flags)));

    // R4: ordered relations reject any NaN
    p_ordered_nan_r4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(in_valid && !in_func && in_sub <= 3'd1 && (cls[0].nan || cls[1].nan)))
        |-> (out_result == '0 && out_flags == 5'b10000));

    // R5: equality flags signaling NaNs only, and never reports a NaN equal
    p_eq_flag_r5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(in_valid && !in_func && in_sub == 3'd2))
        |-> (out_flags[FLAG_INVALID] == $past(cls[0].snan || cls[1].snan)
             && (!$past(cls[0].nan || cls[1].nan) || out_result == '0)));

    // R7: a signaling second operand yields the first operand
    p_mm_snan_b_r7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(in_valid && in_func && in_sub <= 3'd1 && cls[1].snan))
        |-> (out_result == $past(in_a) && out_flags[FLAG_INVALID]));

    // R8: a signaling first operand alone yields the second operand
    p_mm_snan_a_r8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(in_valid && in_func && in_sub <= 3'd1 && cls[0].snan && !cls[1].snan))
        |-> (out_result == $past(in_b) && out_flags[FLAG_INVALID]));

    // R9: two quiet NaNs collapse to the canonical NaN
    p_mm_qnan_pair_r9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(in_valid && in_func && in_sub <= 3'd1 && cls[0].nan && cls[1].nan
                              && !cls[0].snan && !cls[1].snan))
        |-> (out_result == CANON_NAN && out_flags == '0));

    // R10: undefined codes produce nothing
    p_bad_sub_r10: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(in_valid && op == OP_NONE))
        |-> (out_result == '0 && out_flags == '0));

endmodule

// File: tb/test_fpcmp_unit.sv
module test_fpcmp_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_func = 1'b0;
    logic [2:0]  in_sub = 3'd0;
    logic [31:0] in_a = '0;
    logic [31:0] in_b = '0;
    logic        out_valid;
    logic [31:0] out_result;
    logic [4:0]  out_flags;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    fpcmp_unit i_fpcmp_unit (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_func    (in_func),
        .in_sub     (in_sub),
        .in_a       (in_a),
        .in_b       (in_b),
        .out_valid  (out_valid),
        .out_result (out_result),
        .out_flags  (out_flags)
    );

    typedef struct packed {
        logic        fn;
        logic [2:0]  sub;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] res;
        logic        inv;
        logic [3:0]  req;
    } vec_t;

    localparam logic [31:0] P1 = 32'h3F80_0000, P2 = 32'h4000_0000;
    localparam logic [31:0] N1 = 32'hBF80_0000, N2 = 32'hC000_0000;
    localparam logic [31:0] PZ = 32'h0000_0000, NZ = 32'h8000_0000;
    localparam logic [31:0] QN = 32'h7FC0_0000, QX = 32'h7FC0_0123, QNEG = 32'hFFC0_0000;
    localparam logic [31:0] SN = 32'h7F80_0001, SNEG = 32'hFFA0_0000;
    localparam logic [31:0] PINF = 32'h7F80_0000, NINF = 32'hFF80_0000;

    localparam int NV = 40;
    localparam vec_t VECS [NV] = '{
        // R3: ordered and equality relations on numbers
        '{1'b0, 3'd0, P1, P2, 32'd1, 1'b0, 4'd3},
        '{1'b0, 3'd0, P2, P1, 32'd0, 1'b0, 4'd3},
        '{1'b0, 3'd0, P1, P1, 32'd1, 1'b0, 4'd3},
        '{1'b0, 3'd1, P1, P1, 32'd0, 1'b0, 4'd3},
        '{1'b0, 3'd1, N2, N1, 32'd1, 1'b0, 4'd3},
        '{1'b0, 3'd1, N1, N2, 32'd0, 1'b0, 4'd3},
        '{1'b0, 3'd2, NZ, PZ, 32'd1, 1'b0, 4'd3},
        '{1'b0, 3'd0, PZ, NZ, 32'd1, 1'b0, 4'd3},
        '{1'b0, 3'd1, NZ, PZ, 32'd0, 1'b0, 4'd3},
        '{1'b0, 3'd2, P1, P2, 32'd0, 1'b0, 4'd3},
        '{1'b0, 3'd1, N1, P1, 32'd1, 1'b0, 4'd3},
        '{1'b0, 3'd1, P2, PINF, 32'd1, 1'b0, 4'd3},
        // R4: ordered relations with NaN
        '{1'b0, 3'd1, QN, P1, 32'd0, 1'b1, 4'd4},
        '{1'b0, 3'd0, P1, SN, 32'd0, 1'b1, 4'd4},
        '{1'b0, 3'd0, QN, QN, 32'd0, 1'b1, 4'd4},
        // R5: equality with NaN
        '{1'b0, 3'd2, QN, QN, 32'd0, 1'b0, 4'd5},
        '{1'b0, 3'd2, P1, SN, 32'd0, 1'b1, 4'd5},
        '{1'b0, 3'd2, QX, P1, 32'd0, 1'b0, 4'd5},
        '{1'b0, 3'd2, SNEG, SNEG, 32'd0, 1'b1, 4'd5},
        // R6: min/max on numbers and signed zeros
        '{1'b1, 3'd0, P1, P2, P1, 1'b0, 4'd6},
        '{1'b1, 3'd1, P1, P2, P2, 1'b0, 4'd6},
        '{1'b1, 3'd0, NZ, PZ, NZ, 1'b0, 4'd6},
        '{1'b1, 3'd1, NZ, PZ, PZ, 1'b0, 4'd6},
        '{1'b1, 3'd0, PZ, NZ, NZ, 1'b0, 4'd6},
        '{1'b1, 3'd1, N1, N2, N1, 1'b0, 4'd6},
        '{1'b1, 3'd0, NINF, P1, NINF, 1'b0, 4'd6},
        // R7: signaling second operand
        '{1'b1, 3'd0, P1, SN, P1, 1'b1, 4'd7},
        '{1'b1, 3'd1, QN, SN, QN, 1'b1, 4'd7},
        '{1'b1, 3'd1, SN, SNEG, SN, 1'b1, 4'd7},
        // R8: signaling first operand
        '{1'b1, 3'd0, SN, P2, P2, 1'b1, 4'd8},
        '{1'b1, 3'd1, SN, QX, QX, 1'b1, 4'd8},
        // R9: quiet NaNs in min/max
        '{1'b1, 3'd0, QN, P2, P2, 1'b0, 4'd9},
        '{1'b1, 3'd1, N1, QN, N1, 1'b0, 4'd9},
        '{1'b1, 3'd0, QX, QX, QN, 1'b0, 4'd9},
        '{1'b1, 3'd1, QNEG, QN, QN, 1'b0, 4'd9},
        // R10: undefined sub-operation codes
        '{1'b0, 3'd3, P1, P1, 32'd0, 1'b0, 4'd10},
        '{1'b0, 3'd7, QN, SN, 32'd0, 1'b0, 4'd10},
        '{1'b1, 3'd2, P1, P2, 32'd0, 1'b0, 4'd10},
        '{1'b1, 3'd5, SN, P1, 32'd0, 1'b0, 4'd10},
        '{1'b1, 3'd7, QN, QN, 32'd0, 1'b0, 4'd10}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one request at a falling edge; results are sampled at the next falling edge
    task automatic issue(input logic fn, input logic [2:0] sub,
                         input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_func  = fn;
        in_sub   = sub;
        in_a     = a;
        in_b     = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", {29'd0, out_valid, 2'b00}, 32'd0);
        chk("R1", out_result, 32'd0);
        chk("R1", {27'd0, out_flags}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", {31'd0, out_valid}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            issue(VECS[i].fn, VECS[i].sub, VECS[i].a, VECS[i].b);
            chk($sformatf("R%0d vec %0d valid", VECS[i].req, i), {31'd0, out_valid}, 32'd1);
            chk($sformatf("R%0d vec %0d result", VECS[i].req, i), out_result, VECS[i].res);
            chk($sformatf("R%0d vec %0d flags", VECS[i].req, i), {27'd0, out_flags},
                {27'd0, VECS[i].inv, 4'b0000});
        end

        // R2: hold while idle, even with changing operands
        issue(1'b1, 3'd1, P1, P2);
        in_func = 1'b0;
        in_sub  = 3'd0;
        in_a    = SN;
        in_b    = QN;
        @(negedge clk);
        chk("R2 idle valid", {31'd0, out_valid}, 32'd0);
        chk("R2 idle result", out_result, P2);
        chk("R2 idle flags", {27'd0, out_flags}, 32'd0);
        @(negedge clk);
        chk("R2 idle result later", out_result, P2);

        // R2: back-to-back requests each land one cycle later
        @(negedge clk);
        in_valid = 1'b1;
        in_func  = 1'b0;
        in_sub   = 3'd1;
        in_a     = QN;
        in_b     = P1;
        @(negedge clk);
        chk("R2 b2b first", out_result, 32'd0);
        chk("R2 b2b first flags", {27'd0, out_flags}, 32'h10);
        in_func = 1'b1;
        in_sub  = 3'd0;
        in_a    = N2;
        in_b    = P1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R2 b2b second", out_result, N2);
        chk("R2 b2b second flags", {27'd0, out_flags}, 32'd0);

        // R1: reset after activity clears outputs
        issue(1'b1, 3'd1, P1, P2);
        rst = 1'b1;
        @(negedge clk);
        chk("R1 reset again result", out_result, 32'd0);
        chk("R1 reset again valid", {31'd0, out_valid}, 32'd0);
        rst = 1'b0;
        @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule